// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (Arithmetic, Logic, Load/Store Subset)

This block is a 32-bit processor core that completes one instruction every clock cycle. It covers a small part of the RISC-V integer set: eight register-register operations, two register-immediate operations, word and byte loads, word and byte stores, and the upper-immediate load. It has no control flow, so the program counter only ever moves forward by one word per cycle. The core reads its instruction from a combinational instruction port addressed by the program counter. It reaches data through a single port made of a combinational read path and a store path with one write enable per byte lane. The memory itself sits outside the core and commits stores on the rising clock edge.

A control decoder turns the opcode and function fields into a small bundle of strobes. A datapath acts on those strobes. It holds the program counter, the 32-entry register file, the immediate generator, the ALU, the load alignment and the store lane steering. Memory is little-endian. Any opcode outside the supported set may do anything.

Top module: `rvMiniCore`

## Requirements
- R1: With `rst` high at a rising edge, the program counter (`imemAddr`) becomes 0 and no store is issued. After that, each rising edge adds 4 to it.
- R2: Opcode 0110011 selects a register operation by funct3: 000 gives ADD, or SUB when bit 30 is set; 100 gives XOR; 110 gives OR; 111 gives AND.
- R3: Register funct3 010 (SLT) writes 1 if rs1 is less than rs2 as signed 32-bit values, and 0 otherwise.
- R4: Register funct3 001 (SLL) shifts left and funct3 101 with bit 30 set (SRA) shifts right arithmetically. Both use only rs2[4:0] as the amount, and SRA fills with the sign bit.
- R5: Opcode 0010011 with funct3 000 (ADDI) adds, and with funct3 111 (ANDI) ANDs, rs1 with the sign-extended 12-bit immediate from bits 31:20.
- R6: Opcode 0110111 (LUI) writes instruction bits 31:12 into the upper 20 bits of rd and zeros the low 12. LUI followed by ADDI can build any 32-bit constant.
- R7: Opcode 0000011 with funct3 010 (LW) puts rs1 + imm on `dmemAddr` and writes the 32-bit word from `dmemRData` to rd.
- R8: Opcode 0000011 with funct3 000 (LB) picks byte lane `dmemAddr[1:0]` of the read word (lane 0 = bits 7:0) and sign-extends it.
- R9: Opcode 0100011 addresses rs1 + imm, where the immediate is bits 31:25 followed by bits 11:7. With funct3 010 (SW) the core drives `dmemWe`=1111 and `dmemWData`=rs2. With funct3 000 (SB) it drives only enable bit `dmemAddr[1:0]` and puts rs2[7:0] in every byte of `dmemWData`, so the other three bytes of the word are kept.
- R10: Register x0 always reads as zero, and writes to it have no effect.
- R11: `dmemWe` is 0000 in every cycle whose instruction is not a store.
- R12: The two byte-reversal programs leave 0x78563412 (mask method) and 0x4c46f413 (byte load/store method), and their XOR is 0x3410c001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Program counter, the instruction fetch address |
| imemData | input | 32 | Instruction word at `imemAddr` (combinational) |
| dmemAddr | output | 32 | Data byte address (rs1 + immediate) |
| dmemWData | output | 32 | Store data, already placed in its byte lanes |
| dmemWe | output | 4 | Per-lane write enables, bit n for bits 8n+7:8n |
| dmemRData | input | 32 | Word at `dmemAddr` with low two bits ignored (combinational) |

## Verification
The bound checker tests the properties that hold on every cycle. These are the reset value of the counter and its fixed step of 4, the absence of write enables for anything but a store, and the shape of the enables: a full mask for a word store and a single lane that matches the low address bits for a byte store. The register contents and ALU results are not visible at the ports, so only the bench scenarios can show them. These cover signed comparison, shift amount masking, sign-filled shifts, immediate sign extension, LUI/ADDI constant building, x0 immunity, byte-load sign extension and the two reversal programs. The bench stores each result to memory and also checks the address and data of every load and store against its own instruction-level model.

// File: rtl/rvMiniPkg.sv
package rvMiniPkg;
  localparam int XLEN  = 32;
  localparam int BYTES = XLEN / 8;
  localparam int LANEW = $clog2(BYTES);
  localparam int SHW   = $clog2(XLEN);

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLT, ALU_SLL, ALU_SRA, ALU_PASSB
  } aluOp_e;

  typedef enum logic [1:0] { IMM_I, IMM_S, IMM_U } immSel_e;

  typedef struct packed {
    logic    regWrite;
    logic    useImm;
    aluOp_e  aluOp;
    immSel_e immSel;
    logic    memRead;
    logic    memWrite;
    logic    byteAccess;
  } ctrl_t;
endpackage

// File: rtl/rvCtrl.sv
module rvCtrl
  import rvMiniPkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       altBit,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_REG: begin
        ctl.regWrite = 1'b1;
        case (funct3)
          3'b000:  ctl.aluOp = altBit ? ALU_SUB : ALU_ADD;
          3'b001:  ctl.aluOp = ALU_SLL;
          3'b010:  ctl.aluOp = ALU_SLT;
          3'b100:  ctl.aluOp = ALU_XOR;
          3'b101:  ctl.aluOp = ALU_SRA;
          3'b110:  ctl.aluOp = ALU_OR;
          3'b111:  ctl.aluOp = ALU_AND;
          default: ctl.aluOp = ALU_ADD;
        endcase
      end
      OPC_IMM: begin
        ctl.regWrite = 1'b1;
        ctl.useImm   = 1'b1;
        ctl.immSel   = IMM_I;
        ctl.aluOp    = (funct3 == 3'b111) ? ALU_AND : ALU_ADD;
      end
      OPC_LOAD: begin
        ctl.regWrite   = 1'b1;
        ctl.useImm     = 1'b1;
        ctl.immSel     = IMM_I;
        ctl.aluOp      = ALU_ADD;
        ctl.memRead    = 1'b1;
        ctl.byteAccess = (funct3[1:0] == 2'b00);
      end
      OPC_STORE: begin
        ctl.useImm     = 1'b1;
        ctl.immSel     = IMM_S;
        ctl.aluOp      = ALU_ADD;
        ctl.memWrite   = 1'b1;
        ctl.byteAccess = (funct3[1:0] == 2'b00);
      end
      OPC_LUI: begin
        ctl.regWrite = 1'b1;
        ctl.useImm   = 1'b1;
        ctl.immSel   = IMM_U;
        ctl.aluOp    = ALU_PASSB;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/rvAlu.sv
module rvAlu
  import rvMiniPkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_e          op,
  output logic [XLEN-1:0] result
);
  logic [SHW-1:0] shAmt;
  assign shAmt = opB[SHW-1:0];

  always_comb begin
    case (op)
      ALU_ADD:   result = opA + opB;
      ALU_SUB:   result = opA - opB;
      ALU_AND:   result = opA & opB;
      ALU_OR:    result = opA | opB;
      ALU_XOR:   result = opA ^ opB;
      ALU_SLT:   result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_SLL:   result = opA << shAmt;
      ALU_SRA:   result = $unsigned($signed(opA) >>> shAmt);
      ALU_PASSB: result = opB;
      default:   result = opA + opB;
    endcase
  end
endmodule

// File: rtl/rvRegFile.sv
module rvRegFile
  import rvMiniPkg::*;
#(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [XLEN-1:0] wrData,
  input  logic [AW-1:0]   rdAddrA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);
  logic [NREG-1:0][XLEN-1:0] bank;

  assign bank[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : gEntry
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr == AW'(g))) q <= wrData;
    end
    assign bank[g] = q;
  end

  assign rdDataA = bank[rdAddrA];
  assign rdDataB = bank[rdAddrB];
endmodule

// File: rtl/rvDatapath.sv
module rvDatapath
  import rvMiniPkg::*;
#(
  parameter int NREG = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:7]      instrBits,
  input  ctrl_t            ctl,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  dmemAddr,
  output logic [XLEN-1:0]  dmemWData,
  output logic [BYTES-1:0] dmemWe,
  input  logic [XLEN-1:0]  dmemRData
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0]  rsA, rsB, imm, aluB, aluY, loadVal, wbData, laneShifted;
  logic [LANEW-1:0] lane;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + XLEN'(4);
  end

  always_comb begin
    case (ctl.immSel)
      IMM_S:   imm = {{(XLEN-12){instrBits[31]}}, instrBits[31:25], instrBits[11:7]};
      IMM_U:   imm = {instrBits[31:12], 12'b0};
      default: imm = {{(XLEN-12){instrBits[31]}}, instrBits[31:20]};
    endcase
  end

  rvRegFile #(.NREG(NREG)) uRegs (
    .clk     (clk),
    .wrEn    (ctl.regWrite & ~rst),
    .wrAddr  (instrBits[7+AW-1:7]),
    .wrData  (wbData),
    .rdAddrA (instrBits[15+AW-1:15]),
    .rdAddrB (instrBits[20+AW-1:20]),
    .rdDataA (rsA),
    .rdDataB (rsB)
  );

  assign aluB = ctl.useImm ? imm : rsB;

  rvAlu uAlu (
    .opA    (rsA),
    .opB    (aluB),
    .op     (ctl.aluOp),
    .result (aluY)
  );

  assign lane        = aluY[LANEW-1:0];
  assign laneShifted = dmemRData >> {lane, 3'b000};
  assign loadVal     = ctl.byteAccess ? {{(XLEN-8){laneShifted[7]}}, laneShifted[7:0]}
                                      : dmemRData;
  assign wbData      = ctl.memRead ? loadVal : aluY;

  assign dmemAddr  = aluY;
  assign dmemWData = ctl.byteAccess ? {BYTES{rsB[7:0]}} : rsB;

  always_comb begin
    if (!ctl.memWrite || rst) dmemWe = '0;
    else if (ctl.byteAccess)  dmemWe = BYTES'(1) << lane;
    else                      dmemWe = '1;
  end
endmodule

// File: rtl/rvMiniCore.sv
module rvMiniCore
  import rvMiniPkg::*;
#(
  parameter int NREG = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  imemAddr,
  input  logic [XLEN-1:0]  imemData,
  output logic [XLEN-1:0]  dmemAddr,
  output logic [XLEN-1:0]  dmemWData,
  output logic [BYTES-1:0] dmemWe,
  input  logic [XLEN-1:0]  dmemRData
);
  ctrl_t ctl;

  rvCtrl uCtrl (
    .opcode (imemData[6:0]),
    .funct3 (imemData[14:12]),
    .altBit (imemData[30]),
    .ctl    (ctl)
  );

  rvDatapath #(.NREG(NREG)) uPath (
    .clk       (clk),
    .rst       (rst),
    .instrBits (imemData[31:7]),
    .ctl       (ctl),
    .pc        (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWData (dmemWData),
    .dmemWe    (dmemWe),
    .dmemRData (dmemRData)
  );
endmodule

// File: rtl/rvMiniCoreChk.sv
module rvMiniCoreChk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imemAddr,
  input logic [6:0]  opcode,
  input logic [2:0]  funct3,
  input logic [1:0]  addrLane,
  input logic [3:0]  dmemWe
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) $past(rst) |-> imemAddr == 32'd0);

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> imemAddr == $past(imemAddr) + 32'd4);

  // R11
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode != 7'b0100011) |-> dmemWe == 4'b0000);

  // R9
  sw_full_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 7'b0100011 && funct3 == 3'b010) |-> dmemWe == 4'b1111);

  // R9
  sb_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 7'b0100011 && funct3 == 3'b000) |->
      ($countones(dmemWe) == 1 && dmemWe[addrLane]));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> $onehot0(dmemWe) && dmemWe == 4'b0000);
endmodule

bind rvMiniCore rvMiniCoreChk uChk (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .opcode   (imemData[6:0]),
  .funct3   (imemData[14:12]),
  .addrLane (dmemAddr[1:0]),
  .dmemWe   (dmemWe)
);

// File: tb/sim_rvMiniCore.sv
`timescale 1ns/1ps
module sim_rvMiniCore;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWData, dmemRData;
  logic [3:0]  dmemWe;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] mMem [64];
  logic [31:0] mReg [32];
  logic [31:0] mPc;
  int nIns = 0;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rvMiniCore u0 (.*);

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRData = dmem[dmemAddr[7:2]];

  always @(posedge clk) begin
    if (!rst) begin
      for (int l = 0; l < 4; l++)
        if (dmemWe[l]) dmem[dmemAddr[7:2]][8*l +: 8] <= dmemWData[8*l +: 8];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rT(logic [2:0] f3, logic alt, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {1'b0, alt, 5'b0, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] iT(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [11:0] im);
    return {im, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] sT(logic [2:0] f3, logic [4:0] src, logic [4:0] base, logic [11:0] im);
    return {im[11:5], src, base, f3, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] uT(logic [4:0] rd, logic [19:0] im);
    return {im, rd, 7'b0110111};
  endfunction

  task automatic put(input logic [31:0] w);
    imem[nIns] = w;
    nIns++;
  endtask

  // Instruction-level reference: check this cycle's port values, then advance.
  task automatic modelStep();
    logic [31:0] ins, a, b, iI, iS, res, addr, w;
    logic [3:0]  expWe;
    logic        wr;
    ins = imem[mPc[7:2]];
    a = mReg[ins[19:15]];
    b = mReg[ins[24:20]];
    iI = {{20{ins[31]}}, ins[31:20]};
    iS = {{20{ins[31]}}, ins[31:25], ins[11:7]};
    res = 0; wr = 1'b0; expWe = 4'b0000;
    check("R1 fetch address", imemAddr, mPc);
    case (ins[6:0])
      7'b0110011: begin
        wr = 1'b1;
        case (ins[14:12])
          3'd0: res = ins[30] ? a - b : a + b;
          3'd1: res = a << b[4:0];
          3'd2: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          3'd4: res = a ^ b;
          3'd5: res = $signed(a) >>> b[4:0];
          3'd6: res = a | b;
          default: res = a & b;
        endcase
      end
      7'b0010011: begin
        wr = 1'b1;
        res = (ins[14:12] == 3'd7) ? (a & iI) : (a + iI);
      end
      7'b0000011: begin
        wr = 1'b1;
        addr = a + iI;
        w = mMem[addr[7:2]];
        check("R7 load address", dmemAddr, addr);
        if (ins[14:12] == 3'd2) res = w;
        else begin
          res = w >> (8 * addr[1:0]);
          res = {{24{res[7]}}, res[7:0]};
        end
      end
      7'b0100011: begin
        addr = a + iS;
        check("R9 store address", dmemAddr, addr);
        if (ins[14:12] == 3'd2) begin
          expWe = 4'b1111;
          check("R9 word store data", dmemWData, b);
          mMem[addr[7:2]] = b;
        end else begin
          expWe = 4'b0001 << addr[1:0];
          check("R9 byte store data", dmemWData, {4{b[7:0]}});
          mMem[addr[7:2]][8*addr[1:0] +: 8] = b[7:0];
        end
      end
      7'b0110111: begin
        wr = 1'b1;
        res = {ins[31:12], 12'b0};
      end
      default: wr = 1'b0;
    endcase
    check("R11 write enables", {28'b0, dmemWe}, {28'b0, expWe});
    if (wr && ins[11:7] != 5'd0) mReg[ins[11:7]] = res;
    mPc = mPc + 32'd4;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0000_0013;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'h1234_5678;
    dmem[1] = 32'h13f4_464c;
    // byte reversal by masks and shifts into x5
    put(iT(7'h03, 3'd2, 5'd1, 5'd0, 12'd0));
    put(iT(7'h13, 3'd0, 5'd2, 5'd0, 12'd255));
    put(iT(7'h13, 3'd0, 5'd20, 5'd0, 12'd8));
    put(iT(7'h13, 3'd0, 5'd21, 5'd0, 12'd16));
    put(iT(7'h13, 3'd0, 5'd22, 5'd0, 12'd24));
    put(rT(3'd7, 1'b0, 5'd3, 5'd1, 5'd2));
    put(rT(3'd1, 1'b0, 5'd5, 5'd3, 5'd22));
    put(rT(3'd5, 1'b1, 5'd3, 5'd1, 5'd20));
    put(rT(3'd7, 1'b0, 5'd3, 5'd3, 5'd2));
    put(rT(3'd1, 1'b0, 5'd3, 5'd3, 5'd21));
    put(rT(3'd6, 1'b0, 5'd5, 5'd5, 5'd3));
    put(rT(3'd5, 1'b1, 5'd3, 5'd1, 5'd21));
    put(rT(3'd7, 1'b0, 5'd3, 5'd3, 5'd2));
    put(rT(3'd1, 1'b0, 5'd3, 5'd3, 5'd20));
    put(rT(3'd6, 1'b0, 5'd5, 5'd5, 5'd3));
    put(rT(3'd5, 1'b1, 5'd3, 5'd1, 5'd22));
    put(rT(3'd7, 1'b0, 5'd3, 5'd3, 5'd2));
    put(rT(3'd6, 1'b0, 5'd5, 5'd5, 5'd3));
    put(sT(3'd2, 5'd5, 5'd0, 12'd8));
    // byte reversal by byte loads and stores, reload into x6
    put(iT(7'h03, 3'd0, 5'd12, 5'd0, 12'd4));
    put(iT(7'h03, 3'd0, 5'd13, 5'd0, 12'd5));
    put(iT(7'h03, 3'd0, 5'd14, 5'd0, 12'd6));
    put(iT(7'h03, 3'd0, 5'd15, 5'd0, 12'd7));
    put(sT(3'd0, 5'd15, 5'd0, 12'd4));
    put(sT(3'd0, 5'd14, 5'd0, 12'd5));
    put(sT(3'd0, 5'd13, 5'd0, 12'd6));
    put(sT(3'd0, 5'd12, 5'd0, 12'd7));
    put(iT(7'h03, 3'd2, 5'd6, 5'd0, 12'd4));
    put(sT(3'd2, 5'd6, 5'd0, 12'd12));
    put(rT(3'd4, 1'b0, 5'd7, 5'd5, 5'd6));
    put(sT(3'd2, 5'd7, 5'd0, 12'd16));
    // corner cases
    put(iT(7'h13, 3'd0, 5'd0, 5'd0, 12'd5));
    put(sT(3'd2, 5'd0, 5'd0, 12'd20));
    put(iT(7'h13, 3'd0, 5'd24, 5'd0, 12'hfff));
    put(iT(7'h13, 3'd0, 5'd25, 5'd0, 12'd1));
    put(rT(3'd2, 1'b0, 5'd26, 5'd24, 5'd25));
    put(rT(3'd2, 1'b0, 5'd27, 5'd25, 5'd24));
    put(sT(3'd2, 5'd26, 5'd0, 12'd24));
    put(sT(3'd2, 5'd27, 5'd0, 12'd28));
    put(rT(3'd0, 1'b1, 5'd28, 5'd25, 5'd24));
    put(sT(3'd2, 5'd28, 5'd0, 12'd32));
    put(uT(5'd16, 20'h12346));
    put(iT(7'h13, 3'd0, 5'd16, 5'd16, 12'h800));
    put(sT(3'd2, 5'd16, 5'd0, 12'd36));
    put(iT(7'h13, 3'd7, 5'd17, 5'd1, 12'hff0));
    put(sT(3'd2, 5'd17, 5'd0, 12'd40));
    put(iT(7'h13, 3'd0, 5'd18, 5'd0, 12'd33));
    put(rT(3'd1, 1'b0, 5'd19, 5'd25, 5'd18));
    put(sT(3'd2, 5'd19, 5'd0, 12'd44));
    put(uT(5'd29, 20'h80000));
    put(rT(3'd5, 1'b1, 5'd30, 5'd29, 5'd20));
    put(sT(3'd2, 5'd30, 5'd0, 12'd48));
    put(iT(7'h03, 3'd0, 5'd31, 5'd0, 12'd5));
    put(sT(3'd2, 5'd31, 5'd0, 12'd52));

    for (int i = 0; i < 64; i++) mMem[i] = dmem[i];
    for (int i = 0; i < 32; i++) mReg[i] = 32'h0;
    mPc = 32'h0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset address", imemAddr, 32'h0);
    check("R1 no store in reset", {28'b0, dmemWe}, 32'h0);
    rst = 1'b0;
    for (int k = 0; k < 60; k++) begin
      modelStep();
      @(negedge clk);
    end

    check("R12 mask reversal", dmem[2], 32'h7856_3412);
    check("R12 byte reversal", dmem[3], 32'h4c46_f413);
    check("R12 xor of both", dmem[4], 32'h3410_c001);
    check("R9 byte stores keep other lanes", dmem[1], 32'h4c46_f413);
    check("R7 source word unchanged", dmem[0], 32'h1234_5678);
    check("R10 x0 stays zero", dmem[5], 32'h0);
    check("R3 signed less true", dmem[6], 32'h1);
    check("R3 signed less false", dmem[7], 32'h0);
    check("R2 subtract", dmem[8], 32'h2);
    check("R6 lui plus negative addi", dmem[9], 32'h1234_5800);
    check("R5 andi sign-extended", dmem[10], 32'h1234_5670);
    check("R4 shift amount low five bits", dmem[11], 32'h2);
    check("R4 arithmetic right shift", dmem[12], 32'hff80_0000);
    check("R8 byte load sign-extended", dmem[13], 32'hffff_fff4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule